// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers interrupt requests from four devices and turns them into a single interrupt line for a processor. Each request is level-sensitive. While it is high, it is captured into a pending register, and it stays there until the processor services it. A mask register written by the processor passes or blocks each pending bit. A fixed-priority encoder picks one winner among the unmasked pending bits and produces a 2-bit device code. A global enable latch, set and cleared by the processor, gates the interrupt line for all devices at once.

The processor services an interrupt by raising its acknowledge. The vector is handed over only when three things hold in the same cycle: a pending unmasked request, the enable latch, and the acknowledge. In that cycle the controller drives a vector onto the bus and raises its valid strobe. The vector is a base value with the device code in its two low bits. On the next clock edge, the serviced device's pending bit is dropped and the enable latch closes. The processor must reopen the latch before a further interrupt can be signalled.

The vector output has no back-pressure. The acknowledge plays the role of ready, and the vector is valid only in a cycle where both are high.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset (`rst_n` low at a clock edge), the pending register is 0, the enable latch is closed, the mask is all ones, and `irq_out`, `vec_valid` and `vec_data` are all 0.
- R2: A request input that is high at a clock edge sets its pending bit. The bit stays set after the input falls, until that device is serviced or reset occurs.
- R3: A pending bit whose mask bit is 0 never causes `irq_out` or a vector. The bit remains latched, and it takes effect once the mask bit is written to 1. `mask_wr` loads `mask_wdata` at the clock edge.
- R4: Among unmasked pending devices, device 0 wins over 1, 1 over 2, and 2 over 3. The device code is 11, 10, 01 and 00 for devices 0, 1, 2 and 3.
- R5: `irq_out` is high exactly when at least one unmasked bit is pending and the enable latch is open.
- R6: `gate_set` opens the enable latch at the clock edge. `gate_clr` closes it, and clear wins if both are high in the same cycle.
- R7: `vec_valid` is high only in a cycle where `irq_out` and `ack` are both high. In that cycle `vec_data` equals `VEC_BASE` with its two low bits replaced by the winning device code. In every other cycle `vec_data` is 0.
- R8: At the edge that ends a cycle with `vec_valid` high, the winner's pending bit is cleared and the enable latch closes. A request still high at that edge sets its pending bit again.
- R9: `ack` has no effect while `irq_out` is low: no vector is driven and no pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | 4 | Level request per device |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 4 | New mask value, 1 = pass |
| gate_set | input | 1 | Open the global enable latch |
| gate_clr | input | 1 | Close the global enable latch |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Processor acknowledge (vector ready) |
| vec_data | output | 8 | Vector address, valid with vec_valid |
| vec_valid | output | 1 | Vector valid strobe |

## Verification
The assertions assume that the inputs are driven synchronously and are free of X after reset. The pending-bit accounting check additionally assumes that no request is raised in a cycle where the conclusion is drawn, and it is guarded on that condition. The bench changes all inputs only on the falling clock edge. It holds request inputs at 0 while it counts serviced bits, and it raises them together with an acknowledge only in the dedicated re-latch case.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC_DEF = 4;

  // Device code: highest-priority (index 0) gets the all-ones code.
  function automatic int unsigned dev_code(input int unsigned idx, input int unsigned nsrc);
    return nsrc - 1 - idx;
  endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            mask_wr_i,
  input  logic [NSRC-1:0] mask_wdata_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] mask_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_o[g] <= 1'b0;
        mask_o[g] <= 1'b1;
      end else begin
        pend_o[g] <= (pend_o[g] & ~clr_i[g]) | req_i[g];
        if (mask_wr_i) mask_o[g] <= mask_wdata_i[g];
      end
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int NSRC   = 4,
  localparam int CW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] active_i,
  output logic            any_o,
  output logic [CW-1:0]   code_o,
  output logic [NSRC-1:0] win_o
);
  always_comb begin
    code_o = '0;
    win_o  = '0;
    // Scan lowest priority first so the highest-priority hit is kept last.
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active_i[i]) begin
        code_o = CW'(dev_code(i, NSRC));
        win_o  = NSRC'(1) << i;
      end
    end
    any_o = |active_i;
  end
endmodule

// File: rtl/irq_vec_gate.sv
module irq_vec_gate #(
  parameter int             NSRC     = 4,
  parameter int             VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'hA8,
  localparam int            CW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             any_i,
  input  logic             ack_i,
  input  logic [CW-1:0]    code_i,
  output logic             en_o,
  output logic             irq_o,
  output logic             grant_o,
  output logic [VEC_W-1:0] vec_o
);
  assign irq_o   = any_i & en_o;
  assign grant_o = irq_o & ack_i;
  assign vec_o   = grant_o ? {VEC_BASE[VEC_W-1:CW], code_i} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                 en_o <= 1'b0;
    else if (clr_i || grant_o)  en_o <= 1'b0;
    else if (set_i)             en_o <= 1'b1;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int               NSRC     = 4,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'hA8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  dev_req,
  input  logic             mask_wr,
  input  logic [NSRC-1:0]  mask_wdata,
  input  logic             gate_set,
  input  logic             gate_clr,
  output logic             irq_out,
  input  logic             ack,
  output logic [VEC_W-1:0] vec_data,
  output logic             vec_valid
);
  localparam int CW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] pend, mask, win, clr;
  logic            any, en, grant;
  logic [CW-1:0]   code;

  assign clr = grant ? win : '0;

  irq_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(dev_req), .clr_i(clr),
    .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata),
    .pend_o(pend), .mask_o(mask)
  );

  irq_prio_enc #(.NSRC(NSRC)) u_enc (
    .active_i(pend & mask), .any_o(any), .code_o(code), .win_o(win)
  );

  irq_vec_gate #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_gate (
    .clk(clk), .rst_n(rst_n), .set_i(gate_set), .clr_i(gate_clr),
    .any_i(any), .ack_i(ack), .code_i(code), .en_o(en),
    .irq_o(irq_out), .grant_o(grant), .vec_o(vec_data)
  );

  assign vec_valid = grant;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int               NSRC     = 4,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'hA8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  dev_req,
  input logic             mask_wr,
  input logic [NSRC-1:0]  mask_wdata,
  input logic             gate_clr,
  input logic             irq_out,
  input logic             ack,
  input logic [VEC_W-1:0] vec_data,
  input logic             vec_valid,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  mask
);
  localparam int CW = (NSRC > 1) ? $clog2(NSRC) : 1;

  AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |-> (irq_out && ack)); // R7
  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |-> vec_data[VEC_W-1:CW] == VEC_BASE[VEC_W-1:CW]); // R7
  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !vec_valid |-> vec_data == '0); // R7
  AST_ACK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |=> !irq_out); // R8
  AST_ACK_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && dev_req == '0) |=> $countones(pend) == $countones($past(pend)) - 1); // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && dev_req == '0) |=> pend == $past(pend)); // R2
  AST_CLR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) gate_clr |=> !irq_out); // R6
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) mask_wr |=> mask == $past(mask_wdata)); // R3
  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> (pend & mask) != '0); // R5
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
  .gate_clr(gate_clr), .irq_out(irq_out), .ack(ack), .vec_data(vec_data),
  .vec_valid(vec_valid), .pend(pend), .mask(mask)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam logic [7:0] BASE = 8'hA8;

  logic clk = 0, rst_n = 0;
  logic [3:0] dev_req = 0, mask_wdata = 0;
  logic mask_wr = 0, gate_set = 0, gate_clr = 0, ack = 0;
  logic irq_out, vec_valid;
  logic [7:0] vec_data;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .gate_set(gate_set), .gate_clr(gate_clr),
    .irq_out(irq_out), .ack(ack), .vec_data(vec_data), .vec_valid(vec_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: inputs held from the last falling edge, settle before sampling.
  task automatic tick();
    @(posedge clk); @(negedge clk);
    dev_req = 0; mask_wr = 0; gate_set = 0; gate_clr = 0; ack = 0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(); rst_n = 1;
  endtask

  function automatic int lowest(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 irq", irq_out, 0);
    chk("R1 valid", vec_valid, 0);
    chk("R1 vec", vec_data, 0);
    ack = 1; #1;
    chk("R1 closed latch blocks", vec_valid, 0);
    tick();

    // Exhaustive sweep: every request pattern against every mask.
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        logic [3:0] pend_e;
        do_reset();
        mask_wr = 1; mask_wdata = m[3:0]; dev_req = p[3:0]; tick();
        pend_e = p[3:0];
        chk("R5 latch closed", irq_out, 0);
        ack = 1; #1;
        chk("R9 ack ignored", vec_valid, 0);
        tick();
        for (int k = 0; k < 5; k++) begin
          gate_set = 1; tick();
          chk("R3/R5 irq", irq_out, ((pend_e & m[3:0]) != 0));
          if ((pend_e & m[3:0]) == 0) break;
          ack = 1; #1;
          chk("R7 valid", vec_valid, 1);
          chk("R4/R7 vector", vec_data, BASE | (3 - lowest(pend_e & m[3:0])));
          pend_e[lowest(pend_e & m[3:0])] = 0;
          tick();
          chk("R8 latch closed", irq_out, 0);
        end
        // Masked bits are still latched: open the mask and drain them.
        if ((pend_e & ~m[3:0]) != 0) begin
          mask_wr = 1; mask_wdata = 4'hF; gate_set = 1; tick();
          chk("R3 masked bit held", irq_out, 1);
          ack = 1; #1;
          chk("R3/R4 vector", vec_data, BASE | (3 - lowest(pend_e)));
          tick();
        end
      end
    end

    // R2: a one-cycle pulse stays pending.
    do_reset();
    dev_req = 4'b1000; tick(); tick(); tick();
    gate_set = 1; tick();
    chk("R2 held", irq_out, 1);
    ack = 1; #1;
    chk("R2 vec dev3", vec_data, BASE | 0);
    tick();

    // R8: request still high at ack edge re-latches.
    do_reset();
    dev_req = 4'b0010; gate_set = 1; tick();
    ack = 1; dev_req = 4'b0010; #1;
    chk("R8 vec dev1", vec_data, BASE | 2);
    tick();
    gate_set = 1; tick();
    chk("R8 relatched", irq_out, 1);

    // R6: clear wins over set; clear after set closes.
    do_reset();
    dev_req = 4'b0001; gate_set = 1; gate_clr = 1; tick();
    chk("R6 clear wins", irq_out, 0);
    gate_set = 1; tick();
    chk("R6 set opens", irq_out, 1);
    gate_clr = 1; tick();
    chk("R6 clear closes", irq_out, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule